// File: doc/BRIEF.md
# Hysteresis Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a direct-mapped table of 2-bit direction entries, one row selected by the low bits of the branch instruction address above the byte-offset bits. No address tag is stored, so two branches whose addresses agree in the index bits share one entry and steer each other's prediction.

The lookup path takes the fetch address and returns a taken / not-taken guess through combinational logic in the same cycle. A second, independent port accepts a resolved branch: its address, its real outcome and a valid strobe. The addressed entry then moves along a four-state hysteresis machine at the next rising clock edge. In that machine a strong state needs two opposite outcomes in a row before the prediction flips. The weakly-taken state drops straight to strongly-not-taken on a single not-taken outcome, and the weakly-not-taken state jumps straight to strongly-taken on a single taken outcome. The table depth and the address geometry are parameters. Four entries with 32-bit addresses is the default.

Top module: `hyst_branch_predictor`

## Requirements
- R1: A synchronous active-high reset clears every entry to state 00 (strongly not taken), so every lookup after reset predicts not taken.
- R2: The prediction is bit 1 of the addressed entry (states 11 and 10 predict taken, 01 and 00 predict not taken) and follows the lookup address in the same cycle without a clock edge.
- R3: The entry index is address bits [ALIGN_BITS+IDX_W-1:ALIGN_BITS] (bits [3:2] by default); all higher and lower address bits are ignored, so aliasing addresses share an entry.
- R4: From 00 a taken outcome moves to 01, which still predicts not taken; a second taken outcome moves 01 to 11, which predicts taken.
- R5: From 11 a not-taken outcome moves to 10, which still predicts taken; a taken outcome moves 10 back to 11.
- R6: From 10 a not-taken outcome moves to 00, so one later taken outcome still leaves the prediction not taken.
- R7: From 01 a not-taken outcome moves to 00, so two more taken outcomes are needed before the entry predicts taken.
- R8: A not-taken outcome leaves 00 unchanged and a taken outcome leaves 11 unchanged.
- R9: With the update valid strobe low nothing changes, and an update changes only the entry its address selects.
- R10: When a lookup and an update address the same entry in one cycle, the lookup returns the state held before that update.
- R11: With four entries, a nested loop with the inner branch at address 16 (8 iterations) and the outer branch at address 28 (4 iterations), each branch looked up and updated in one cycle, gives 27 correct predictions and 9 mispredictions from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| upd_valid | input | 1 | Resolved-branch strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A prediction is due in the same cycle as its lookup address, so the bench drives each address just after a rising edge and compares the output at the following falling edge. An update takes effect at the first rising edge after it is presented, so the next cycle's lookup is the earliest one that sees it. A lookup in the update's own cycle must still see the old state. The bench drives one lookup and at most one update per cycle and queues one expected prediction per cycle. Each expected value comes from a requirement-level table of the four-state machine, which keeps every comparison aligned to exactly one clock edge of latency.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

   typedef logic [1:0] hyst_t;

   localparam hyst_t HY_STRONG_NT = 2'b00;
   localparam hyst_t HY_WEAK_NT   = 2'b01;
   localparam hyst_t HY_WEAK_T    = 2'b10;
   localparam hyst_t HY_STRONG_T  = 2'b11;

   // Four-state hysteresis: weak states fall to the strong state of the outcome.
   function automatic hyst_t hyst_next(input hyst_t cur, input logic taken);
      hyst_t nxt;
      case (cur)
         HY_STRONG_NT: nxt = taken ? HY_WEAK_NT  : HY_STRONG_NT;
         HY_WEAK_NT:   nxt = taken ? HY_STRONG_T : HY_STRONG_NT;
         HY_WEAK_T:    nxt = taken ? HY_STRONG_T : HY_STRONG_NT;
         default:      nxt = taken ? HY_STRONG_T : HY_WEAK_T;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/bhp_upd_decode.sv
module bhp_upd_decode #(
   parameter int ENTRIES = 4,
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               valid,
   input  logic [IDX_W-1:0]   idx,
   output logic [ENTRIES-1:0] sel
);

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
         assign sel[g] = valid && (idx == IDX_W'(g));
      end
   endgenerate

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel)); // R9

   AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
      !valid |-> (sel == '0)); // R9

endmodule

// File: rtl/bhp_entry.sv
module bhp_entry
   import bhp_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  upd_en,
   input  logic  upd_taken,
   output hyst_t state
);

   always_ff @(posedge clk) begin
      if (rst)
         state <= HY_STRONG_NT;
      else if (upd_en)
         state <= hyst_next(state, upd_taken);
   end

   AST_RST_CLEARS: assert property (@(posedge clk)
      rst |=> (state == HY_STRONG_NT)); // R1

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !upd_en |=> $stable(state)); // R9

   AST_WEAK_NT_JUMPS: assert property (@(posedge clk) disable iff (rst)
      (upd_en && upd_taken && state == HY_WEAK_NT) |=> (state == HY_STRONG_T)); // R4

   AST_STRONG_T_SOFTENS: assert property (@(posedge clk) disable iff (rst)
      (upd_en && !upd_taken && state == HY_STRONG_T) |=> (state == HY_WEAK_T)); // R5

   AST_WEAK_T_DROPS: assert property (@(posedge clk) disable iff (rst)
      (upd_en && !upd_taken && state == HY_WEAK_T) |=> (state == HY_STRONG_NT)); // R6

   AST_WEAK_NT_DROPS: assert property (@(posedge clk) disable iff (rst)
      (upd_en && !upd_taken && state == HY_WEAK_NT) |=> (state == HY_STRONG_NT)); // R7

   AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
      (upd_en && (state == {2{upd_taken}})) |=> $stable(state)); // R8

endmodule

// File: rtl/hyst_branch_predictor.sv
module hyst_branch_predictor
   import bhp_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int ENTRIES    = 4,
   parameter int ALIGN_BITS = 2,
   localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int IDX_LO    = ALIGN_BITS,
   localparam int IDX_HI    = ALIGN_BITS + IDX_W - 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);

   generate
      if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_depth
         $error("ENTRIES must be a power of two, at least 2");
      end
      if (IDX_HI >= PC_W) begin : g_bad_geom
         $error("index field does not fit inside PC_W");
      end
   endgenerate

   logic [IDX_W-1:0]   lk_idx;
   logic [IDX_W-1:0]   up_idx;
   logic [ENTRIES-1:0] up_sel;
   hyst_t              tbl [ENTRIES];

   assign lk_idx = lk_pc[IDX_HI:IDX_LO];
   assign up_idx = upd_pc[IDX_HI:IDX_LO];

   bhp_upd_decode #(.ENTRIES(ENTRIES)) u_dec (
      .clk   (clk),
      .rst   (rst),
      .valid (upd_valid),
      .idx   (up_idx),
      .sel   (up_sel)
   );

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_row
         bhp_entry u_ent (
            .clk       (clk),
            .rst       (rst),
            .upd_en    (up_sel[e]),
            .upd_taken (upd_taken),
            .state     (tbl[e])
         );
      end
   endgenerate

   // Read straight from the registers: a same-cycle update is not yet visible.
   assign lk_taken = tbl[lk_idx][1];

   AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
      !$isunknown(lk_pc) && (!upd_valid || !$isunknown(upd_pc))); // R3

   AST_IDLE_PRED_STABLE: assert property (@(posedge clk) disable iff (rst)
      !upd_valid |=> (!$stable(lk_pc) || $stable(lk_taken))); // R9

   AST_RESET_PRED_NT: assert property (@(posedge clk)
      rst |=> !lk_taken); // R1

endmodule

// File: tb/hyst_branch_predictor_tb_top.sv
module hyst_branch_predictor_tb_top;

   localparam int PC_W = 32;
   localparam int ENTRIES = 4;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [PC_W-1:0] lk_pc = '0;
   logic            lk_taken;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic            upd_taken = 1'b0;

   always #2 clk = ~clk;

   hyst_branch_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .lk_pc     (lk_pc),
      .lk_taken  (lk_taken),
      .upd_valid (upd_valid),
      .upd_pc    (upd_pc),
      .upd_taken (upd_taken)
   );

   typedef struct {
      logic  exp;
      logic  actual;
      logic  loop_item;
      string req;
   } sb_item_t;

   sb_item_t   sb_q[$];
   int         checks = 0;
   int         fails = 0;
   int         hits = 0;
   int         misses = 0;
   bit         done = 1'b0;
   logic [1:0] model [ENTRIES];

   // Requirement-level state table (R4..R8).
   function automatic logic [1:0] model_next(input logic [1:0] s, input logic t);
      case (s)
         2'b00:   return t ? 2'b01 : 2'b00;
         2'b01:   return t ? 2'b11 : 2'b00;
         2'b10:   return t ? 2'b11 : 2'b00;
         default: return t ? 2'b11 : 2'b10;
      endcase
   endfunction

   // Index per R3: bits [3:2].
   function automatic int row_of(input logic [PC_W-1:0] pc);
      return int'(pc[3:2]);
   endfunction

   task automatic drive(input logic [PC_W-1:0] lpc, input logic uv,
                        input logic [PC_W-1:0] upc, input logic ut,
                        input logic loop_item, input string req);
      sb_item_t it;
      @(posedge clk);
      #1;
      lk_pc = lpc;
      upd_valid = uv;
      upd_pc = upc;
      upd_taken = ut;
      it.exp = model[row_of(lpc)][1];
      it.actual = ut;
      it.loop_item = loop_item;
      it.req = req;
      sb_q.push_back(it);
      if (uv) model[row_of(upc)] = model_next(model[row_of(upc)], ut);
   endtask

   task automatic look(input logic [PC_W-1:0] lpc, input string req);
      drive(lpc, 1'b0, '0, 1'b0, 1'b0, req);
   endtask

   task automatic lu(input logic [PC_W-1:0] pc, input logic ut, input string req);
      drive(pc, 1'b1, pc, ut, 1'b0, req);
   endtask

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst = 1'b1;
      upd_valid = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b0;
      for (int i = 0; i < ENTRIES; i++) model[i] = 2'b00;
   endtask

   task automatic check_count(input int got, input int want, input string req);
      checks++;
      if (got != want) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, got, want);
      end
   endtask

   // Monitor: one expected prediction per cycle, compared at the falling edge.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         checks++;
         if (lk_taken !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", it.req, lk_taken, it.exp);
         end
         if (it.loop_item) begin
            if (lk_taken === it.actual) hits++;
            else misses++;
         end
      end
   end

   initial begin
      do_reset();
      // R1: every row predicts not taken
      for (int r = 0; r < ENTRIES; r++) look(PC_W'(r * 4), "R1");
      // R4: 00 -T-> 01 (still NT) -T-> 11 (T)
      lu(32'h4, 1'b1, "R4");
      lu(32'h4, 1'b1, "R4");
      look(32'h4, "R4");
      // R8: taken at 11 stays 11
      lu(32'h4, 1'b1, "R8");
      look(32'h4, "R8");
      // R5: 11 -N-> 10 (still T) -T-> 11
      lu(32'h4, 1'b0, "R5");
      look(32'h4, "R5");
      lu(32'h4, 1'b1, "R5");
      look(32'h4, "R5");
      // R6: 11 -N-> 10 -N-> 00, then one taken leaves NT
      lu(32'h4, 1'b0, "R6");
      lu(32'h4, 1'b0, "R6");
      look(32'h4, "R6");
      lu(32'h4, 1'b1, "R6");
      look(32'h4, "R6");
      // R8: not taken at 00 stays 00
      lu(32'h0, 1'b0, "R8");
      look(32'h0, "R8");
      // R7: 00 -T-> 01 -N-> 00, then two takens needed
      lu(32'h8, 1'b1, "R7");
      lu(32'h8, 1'b0, "R7");
      lu(32'h8, 1'b1, "R7");
      look(32'h8, "R7");
      lu(32'h8, 1'b1, "R7");
      look(32'h8, "R7");
      // R9: strobe low has no effect; other rows untouched
      for (int k = 0; k < 3; k++) drive(32'hC, 1'b0, 32'hC, 1'b1, 1'b0, "R9");
      look(32'hC, "R9");
      look(32'h0, "R9");
      // R10: lookup sees pre-update state in the update cycle
      lu(32'h8, 1'b0, "R10");
      lu(32'h8, 1'b0, "R10");
      look(32'h8, "R10");
      // R3: aliasing addresses, upper and offset bits ignored
      drive(32'hABCD_0017, 1'b1, 32'h7000_000B, 1'b1, 1'b0, "R3");
      drive(32'h5555_5559, 1'b1, 32'h0000_0108, 1'b1, 1'b0, "R3");
      look(32'hFFFF_FFFA, "R3");
      look(32'h1234_5677, "R3");
      // R2: prediction follows the lookup address within the cycle
      look(32'h8, "R2");
      look(32'h4, "R2");
      look(32'h8, "R2");
      // R11: nested loop replay from reset
      do_reset();
      for (int o = 0; o < 4; o++) begin
         for (int i = 0; i < 8; i++) drive(32'd16, 1'b1, 32'd16, (i < 7), 1'b1, "R11");
         drive(32'd28, 1'b1, 32'd28, (o < 3), 1'b1, "R11");
      end
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
      @(negedge clk);
      #1;
      check_count(hits, 27, "R11 correct predictions");
      check_count(misses, 9, "R11 mispredictions");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule